// File: doc/BRIEF.md
# Two-Level Stacked Interrupt Controller

This block gathers interrupt events from two producers. The bus-phase producer reports through two status words and the DMA producer through one. All three words hold the same parameterised number of bits. Each word has a visible copy that the host reads and a hidden copy behind it. The hidden copy catches the events that arrive while an interrupt is still being serviced. Reading a visible word returns it and clears it. Once no summary flag is left after such a read, the hidden contents move up into the visible words.

Each status bit is either fatal or nonfatal, chosen at build time, and each bit has an enable written by the host. A bit that is enabled, or fatal, counts towards its producer's summary flag. Only enabled bits can pull the active-low interrupt line. When a clearing read empties the visible level, the line is released. It then stays released for a programmable number of cycles before it may be driven again. This lets the host see a fresh edge for any promoted events.

Top module: `stacked_irq_ctrl`

## Requirements
- R1: After reset, irq_n is 1, bus_pend and dma_pend are 0, and every status word reads as zero.
- R2: The register address selects a word: 0 is bus word A, 1 is bus word B, 2 is the DMA word. A read strobe returns the selected word on reg_rdata from the next cycle and clears that word. A write to addresses 0 to 2 loads that word's enable mask, where 1 means enabled. Reading address 3 returns dma_pend in bit 1 and bus_pend in bit 0, and it clears nothing.
- R3: bus_pend is set when any visible bit of word A or word B is enabled or fatal. dma_pend is the same for the DMA word. Both flags follow the visible words and masks at the same clock edge at which those change.
- R4: When no summary flag remains set, counting a clearing read in the same cycle, arriving event bits are ORed into the visible words.
- R5: While a summary flag remains set, arriving event bits are ORed into the hidden level. The visible words are not changed, and repeated events accumulate in the hidden level.
- R6: When the hidden level is non-empty and no flag remains set, the hidden bits are ORed into the visible words and the hidden level is cleared. Events arriving in the same cycle are merged in with them.
- R7: Outside a release gap, irq_n goes low one cycle after a visible word holds an enabled bit.
- R8: A status read that leaves no flag set drives irq_n high at that edge. irq_n then stays high for at least GAP_CYCLES cycles. It goes low again exactly GAP_CYCLES cycles later if enabled bits were promoted, and otherwise stays high.
- R9: A nonfatal bit that is not enabled still sets its visible bit. It sets no flag, does not drive irq_n and causes no stacking. Later enabled events land in the visible word next to it.
- R10: A fatal bit that is not enabled sets its flag without driving irq_n, and events that follow it are stacked.
- R11: Once low, irq_n stays low until a clearing status read. Changing an enable mask does not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_bus_a | input | DW | Event pulses for bus word A |
| ev_bus_b | input | DW | Event pulses for bus word B |
| ev_dma | input | DW | Event pulses for the DMA word |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data (enable mask) |
| reg_rdata | output | DW | Registered read data |
| bus_pend | output | 1 | Bus-phase summary flag |
| dma_pend | output | 1 | DMA summary flag |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The bench builds the block with 8-bit words, a gap of 3 cycles, and bit 0 of every word marked fatal. These values keep every gap count short enough to check cycle by cycle. The fatal bit lets an unenabled fatal event raise its flag and force stacking, while the other bits show the unenabled nonfatal behaviour. With three words, a bench can also arrive on one producer while the other is being cleared, so it can test same-cycle reads and events with both an empty and a filled hidden level.

// File: rtl/stkirq_pkg.sv
package stkirq_pkg;
  typedef enum logic [1:0] {
    ADR_BUS_A = 2'd0,
    ADR_BUS_B = 2'd1,
    ADR_DMA   = 2'd2,
    ADR_FLAGS = 2'd3
  } stkirq_addr_e;

  localparam int NWORDS   = 3;
  localparam int WORD_DMA = 2;
endpackage

// File: rtl/stkirq_word.sv
module stkirq_word #(
  parameter int DW = 8,
  parameter logic [DW-1:0] FATAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_wr,
  input  logic [DW-1:0] wdata,
  input  logic          clr,
  input  logic [DW-1:0] ev,
  input  logic          to_hid,
  input  logic          promote,
  output logic [DW-1:0] vis_q,
  output logic          hid_any,
  output logic          hot_cl,
  output logic          hot_nx,
  output logic          en_hot
);
  logic [DW-1:0] hid_q, en_q;
  logic [DW-1:0] vis_cl, vis_nx, hid_nx, en_nx;

  always_comb begin
    vis_cl = clr ? '0 : vis_q;
    en_nx  = en_wr ? wdata : en_q;
    if (promote) begin
      vis_nx = vis_cl | hid_q | ev;
      hid_nx = '0;
    end else if (to_hid) begin
      vis_nx = vis_cl;
      hid_nx = hid_q | ev;
    end else begin
      vis_nx = vis_cl | ev;
      hid_nx = hid_q;
    end
  end

  assign hot_cl  = |(vis_cl & (en_q | FATAL));
  assign hot_nx  = |(vis_nx & (en_nx | FATAL));
  assign en_hot  = |(vis_q & en_q);
  assign hid_any = |hid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q <= '0;
      hid_q <= '0;
      en_q  <= '0;
    end else begin
      vis_q <= vis_nx;
      hid_q <= hid_nx;
      en_q  <= en_nx;
    end
  end
endmodule

// File: rtl/stkirq_line.sv
module stkirq_line #(
  parameter int GAP_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_stat,
  input  logic pend_q,
  input  logic pend_cl,
  input  logic want,
  output logic irq_n_q
);
  localparam int GW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CYCLES - 1);

  logic [GW-1:0] gap_q;
  logic          release_now;

  assign release_now = rd_stat && (pend_q || !irq_n_q) && !pend_cl;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n_q <= 1'b1;
      gap_q   <= '0;
    end else if (release_now) begin
      irq_n_q <= 1'b1;
      gap_q   <= GAP_LOAD;
    end else begin
      if (gap_q != '0) gap_q <= gap_q - 1'b1;
      if (irq_n_q && gap_q == '0 && want) irq_n_q <= 1'b0;
    end
  end
endmodule

// File: rtl/stacked_irq_ctrl.sv
module stacked_irq_ctrl #(
  parameter int DW = 8,
  parameter int GAP_CYCLES = 3,
  parameter logic [3*DW-1:0] FATAL_MAP = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ev_bus_a,
  input  logic [DW-1:0] ev_bus_b,
  input  logic [DW-1:0] ev_dma,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          bus_pend,
  output logic          dma_pend,
  output logic          irq_n
);
  import stkirq_pkg::*;

  logic [NWORDS-1:0][DW-1:0] ev_w, vis_w;
  logic [NWORDS-1:0] hid_w, hot_cl_w, hot_nx_w, en_hot_w, clr_w, wr_w;
  logic pend_cl, to_hid, promote, rd_stat;
  logic bus_q, dma_q;
  logic [DW-1:0] rdata_q;

  assign ev_w[0]        = ev_bus_a;
  assign ev_w[1]        = ev_bus_b;
  assign ev_w[WORD_DMA] = ev_dma;

  assign rd_stat = reg_rd && (reg_addr != ADR_FLAGS);
  assign pend_cl = |hot_cl_w;
  assign to_hid  = pend_cl;
  assign promote = !pend_cl && (|hid_w);

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    assign clr_w[i] = reg_rd && (reg_addr == 2'(i));
    assign wr_w[i]  = reg_wr && (reg_addr == 2'(i));
    stkirq_word #(
      .DW   (DW),
      .FATAL(FATAL_MAP[i*DW +: DW])
    ) u_word (
      .clk    (clk),
      .rst    (rst),
      .en_wr  (wr_w[i]),
      .wdata  (reg_wdata),
      .clr    (clr_w[i]),
      .ev     (ev_w[i]),
      .to_hid (to_hid),
      .promote(promote),
      .vis_q  (vis_w[i]),
      .hid_any(hid_w[i]),
      .hot_cl (hot_cl_w[i]),
      .hot_nx (hot_nx_w[i]),
      .en_hot (en_hot_w[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q   <= 1'b0;
      dma_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      bus_q <= hot_nx_w[0] | hot_nx_w[1];
      dma_q <= hot_nx_w[WORD_DMA];
      if (reg_rd) begin
        case (reg_addr)
          ADR_BUS_A: rdata_q <= vis_w[0];
          ADR_BUS_B: rdata_q <= vis_w[1];
          ADR_DMA:   rdata_q <= vis_w[WORD_DMA];
          default:   rdata_q <= {{(DW-2){1'b0}}, dma_q, bus_q};
        endcase
      end
    end
  end

  stkirq_line #(.GAP_CYCLES(GAP_CYCLES)) u_line (
    .clk    (clk),
    .rst    (rst),
    .rd_stat(rd_stat),
    .pend_q (bus_q | dma_q),
    .pend_cl(pend_cl),
    .want   (|en_hot_w),
    .irq_n_q(irq_n)
  );

  assign bus_pend  = bus_q;
  assign dma_pend  = dma_q;
  assign reg_rdata = rdata_q;
endmodule

// File: rtl/stacked_irq_ctrl_chk.sv
module stacked_irq_ctrl_chk #(
  parameter int DW = 8,
  parameter int GAP_CYCLES = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic          bus_pend,
  input logic          dma_pend,
  input logic          irq_n
);
  localparam int CW = $clog2(GAP_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(GAP_CYCLES);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= CMAX;
    else if (!irq_n) hi_cnt <= '0;
    else if (hi_cnt != CMAX) hi_cnt <= hi_cnt + 1'b1;
  end

  // R8
  release_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> (hi_cnt >= CMAX));

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(bus_pend || dma_pend));

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !reg_rd) |=> !irq_n);

  // R2
  flags_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 2'd3) |=> (reg_rdata[1:0] == {$past(dma_pend), $past(bus_pend)}));

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_pend && !reg_rd && !reg_wr) |=> bus_pend);
endmodule

bind stacked_irq_ctrl stacked_irq_ctrl_chk #(.DW(DW), .GAP_CYCLES(GAP_CYCLES)) u_chk (.*);

// File: tb/test_stacked_irq_ctrl.sv
module test_stacked_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] ev_bus_a = '0, ev_bus_b = '0, ev_dma = '0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic bus_pend, dma_pend, irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stacked_irq_ctrl #(.DW(DW), .GAP_CYCLES(3), .FATAL_MAP(24'h010101)) i_stacked_irq_ctrl (
    .clk(clk), .rst(rst), .ev_bus_a(ev_bus_a), .ev_bus_b(ev_bus_b), .ev_dma(ev_dma),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_pend(bus_pend), .dma_pend(dma_pend), .irq_n(irq_n));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    reg_rd = 1'b1; reg_addr = a;
    step();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic fire(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] d);
    ev_bus_a = a; ev_bus_b = b; ev_dma = d;
    step();
    ev_bus_a = '0; ev_bus_b = '0; ev_dma = '0;
  endtask

  task automatic drain();
    logic [DW-1:0] d;
    repeat (2) for (int k = 0; k < 3; k++) rd(2'(k), d);
    step(6);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R1 irq_n", irq_n, 1);
    chk("R1 flags", {bus_pend, dma_pend}, 0);
    for (int k = 0; k < 3; k++) begin
      rd(2'(k), d);
      chk("R1 word", d, 0);
    end
  endtask

  task automatic t_basic();
    logic [DW-1:0] d;
    wr(0, 8'hFF);
    fire(8'h02, 0, 0);
    chk("R4 bus_pend", bus_pend, 1);
    chk("R7 irq_n before", irq_n, 1);
    step();
    chk("R7 irq_n low", irq_n, 0);
    rd(0, d);
    chk("R2 read value", d, 8'h02);
    chk("R3 flag cleared", bus_pend, 0);
    chk("R8 release", irq_n, 1);
    rd(0, d);
    chk("R2 read clears", d, 0);
    step(5);
    chk("R8 no reassert", irq_n, 1);
    drain();
  endtask

  task automatic t_stack();
    logic [DW-1:0] d;
    wr(0, 8'hFF); wr(2, 8'hFF);
    fire(8'h04, 0, 0);
    fire(0, 0, 8'h08);
    fire(0, 0, 8'h10);
    chk("R5 dma hidden", dma_pend, 0);
    chk("R5 bus visible", bus_pend, 1);
    chk("R11 irq low", irq_n, 0);
    rd(2, d);
    chk("R5 visible dma empty", d, 0);
    chk("R11 non-clearing read", irq_n, 0);
    rd(0, d);
    chk("R2 bus word", d, 8'h04);
    chk("R6 promoted flag", dma_pend, 1);
    chk("R8 released", irq_n, 1);
    step(); chk("R8 gap 1", irq_n, 1);
    step(); chk("R8 gap 2", irq_n, 1);
    step(); chk("R8 reassert", irq_n, 0);
    rd(2, d);
    chk("R5 hidden OR", d, 8'h18);
    chk("R8 release after dma", irq_n, 1);
    drain();
  endtask

  task automatic t_masked();
    logic [DW-1:0] d;
    wr(0, 8'h04);
    fire(8'h02, 0, 0);
    chk("R9 no flag", bus_pend, 0);
    step(2);
    chk("R9 no irq", irq_n, 1);
    fire(8'h04, 0, 0);
    chk("R9 not stacked", bus_pend, 1);
    step();
    chk("R7 irq", irq_n, 0);
    rd(0, d);
    chk("R9 both bits", d, 8'h06);
    step(5);
    chk("R8 stays high", irq_n, 1);
    drain();
  endtask

  task automatic t_fatal();
    logic [DW-1:0] d;
    wr(2, 8'h00); wr(0, 8'h04);
    fire(0, 0, 8'h01);
    chk("R10 flag", dma_pend, 1);
    step(2);
    chk("R10 no irq", irq_n, 1);
    fire(8'h04, 0, 0);
    chk("R10 stacked", bus_pend, 0);
    rd(2, d);
    chk("R10 fatal bit", d, 8'h01);
    chk("R6 promote", bus_pend, 1);
    chk("R8 high", irq_n, 1);
    step(2);
    chk("R8 gap", irq_n, 1);
    step();
    chk("R8 reassert", irq_n, 0);
    rd(0, d);
    chk("R6 promoted value", d, 8'h04);
    drain();
  endtask

  task automatic t_mask_change();
    logic [DW-1:0] d;
    wr(1, 8'hFF);
    fire(0, 8'h02, 0);
    step();
    chk("R7 irq", irq_n, 0);
    wr(1, 8'h00);
    chk("R11 mask keeps irq", irq_n, 0);
    chk("R3 flag follows mask", bus_pend, 0);
    step();
    chk("R11 still low", irq_n, 0);
    rd(1, d);
    chk("R2 word B", d, 8'h02);
    chk("R11 clearing read", irq_n, 1);
    drain();
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] d;
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF);
    fire(8'h02, 0, 0);
    step();
    reg_rd = 1'b1; reg_addr = 2'd0; ev_dma = 8'h20;
    step();
    reg_rd = 1'b0; ev_dma = '0;
    chk("R2 read with event", reg_rdata, 8'h02);
    chk("R4 event visible", dma_pend, 1);
    chk("R4 bus cleared", bus_pend, 0);
    rd(2, d);
    chk("R4 dma value", d, 8'h20);
    drain();
    fire(8'h02, 0, 0);
    fire(0, 0, 8'h40);
    reg_rd = 1'b1; reg_addr = 2'd0; ev_bus_b = 8'h08;
    step();
    reg_rd = 1'b0; ev_bus_b = '0;
    chk("R6 merge flags", {bus_pend, dma_pend}, 2'b11);
    rd(3, d);
    chk("R2 flags read", d, 8'h03);
    rd(3, d);
    chk("R2 flags nondestructive", d, 8'h03);
    rd(1, d);
    chk("R6 merged event", d, 8'h08);
    rd(2, d);
    chk("R6 promoted dma", d, 8'h40);
    drain();
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step();
    t_reset();
    t_basic();
    t_stack();
    t_masked();
    t_fatal();
    t_mask_change();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule